// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Status Flag Rules

This block is the purely combinational execute stage of a sixteen-bit processor with two-operand instructions. The surrounding datapath fetches the operands and hands it a source word, a destination word, the current carry flag, a four-bit operation code, a byte/word select and a flag that marks a single-operand instruction. In the same cycle the block returns the result, a strobe saying whether the destination is to be written, a strobe saying whether the status flags are to be updated, and the new negative, zero, carry and overflow values.

Its flag behaviour is deliberately irregular. Subtraction reports a true carry rather than a borrow. Logical operations report carry as the inverse of zero. Moves and bit set/clear leave the flags alone. Compare and bit-test touch only the flags. Decimal addition treats each nibble as a packed BCD digit. The single-operand group provides rotate through carry, arithmetic shift right, byte swap and sign extension.

Top module: `alu16_core`

## Requirements
- R1: With `unary_i`=0, codes 5 (ADD), 6 (ADDC), 7 (SUBC) and 8 (SUB) give dst+src, dst+src+carry_i, dst+~src+carry_i and dst+~src+1 respectively, and assert `wr_en_o` and `flag_en_o`.
- R2: Subtraction (codes 7, 8 and compare code 9) reports a true carry: `c_o`=1 exactly when the unsigned sum dst+~src+cin carries out, so it means no borrow.
- R3: For codes 5 to 9, `v_o` is 1 exactly when the two addends (dst and the possibly inverted src) share a sign and the result sign differs.
- R4: Codes 11 (BIT, dst&src), 14 (XOR) and 15 (AND) update all flags with `c_o` = not `z_o` and `v_o`=0.
- R5: Codes 4 (MOV, result src), 12 (BIC, dst&~src) and 13 (BIS, dst|src) write the destination but keep `flag_en_o`=0. Whenever `flag_en_o` is 0, all four flag outputs are 0.
- R6: Codes 9 (CMP) and 11 (BIT) drive `flag_en_o`=1 and `wr_en_o`=0.
- R7: Code 10 (DADD) adds dst, src and carry_i digit by digit from the least significant nibble. A digit sum s of 10 or more yields digit (s+6) mod 16 and a carry into the next digit. The last carry goes to `c_o`, and `v_o` is 0.
- R8: With `unary_i`=1, `op_i[1:0]` selects 0 rotate right through carry, 1 byte swap, 2 arithmetic shift right, 3 sign extend low byte; `op_i[3:2]` are ignored and the operand is `src_i`. Rotate and shift put the old bit 0 in `c_o` with `v_o`=0. Sign extend follows the R4 flag rule. Byte swap updates no flag. All four write.
- R9: With `byte_i`=1, result bits 15:8 are zero, and N, carry and overflow come from bit 7 and the 8-bit carry. Byte swap and sign extend ignore `byte_i`.
- R10: With `unary_i`=0, codes 0 to 3 produce result 0, no write and no flag update.
- R11: When `flag_en_o`=1, `n_o` is the result sign bit for the active width, and `z_o` is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 16 | Source operand (sole operand of single-operand operations) |
| dst_i | input | 16 | Destination operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte width |
| unary_i | input | 1 | 1 selects the single-operand group |
| res_o | output | 16 | Result |
| wr_en_o | output | 1 | Destination write strobe |
| flag_en_o | output | 1 | Status flag update strobe |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow flag |

## Verification
Every operation code in both widths and with both carry inputs is crossed with a 32-value operand set. The set includes signed and unsigned boundaries (0, 1, 7FFF, 8000, FFFF, 007F, 0080, 00FF), so it separates carry from borrow, catches overflow in both directions and catches flags taken from the wrong bit. Alternating and random-like words catch swapped or inverted operands in logical operations and in byte swap. Every pair of two-digit decimal values, with both carry inputs and with non-zero upper bytes, distinguishes a correct decimal adjust and digit carry from binary addition and from a missing upper-byte clear.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd4,
        OP_ADD  = 4'd5,
        OP_ADDC = 4'd6,
        OP_SUBC = 4'd7,
        OP_SUB  = 4'd8,
        OP_CMP  = 4'd9,
        OP_DADD = 4'd10,
        OP_BIT  = 4'd11,
        OP_BIC  = 4'd12,
        OP_BIS  = 4'd13,
        OP_XOR  = 4'd14,
        OP_AND  = 4'd15
    } two_op_e;

    typedef enum logic [1:0] {
        UN_RRC  = 2'd0,
        UN_SWPB = 2'd1,
        UN_RRA  = 2'd2,
        UN_SXT  = 2'd3
    } unary_e;

    typedef enum logic [2:0] {
        FC_NONE,
        FC_ARITH,
        FC_LOGIC,
        FC_BCD,
        FC_SHIFT
    } flag_cls_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              wr;
        logic              fe;
        logic              n;
        logic              z;
        logic              c;
        logic              v;
    } alu_out_t;

endpackage

// File: rtl/alu16_adder.sv
module alu16_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int HW = W / 2;

    logic [W:0]  full_d;
    logic [HW:0] half_d;
    logic        a_top, b_top, s_top;

    always_comb begin
        full_d = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        half_d = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
        if (byte_i) begin
            sum_o  = {{(W-HW){1'b0}}, half_d[HW-1:0]};
            cout_o = half_d[HW];
            a_top  = a_i[HW-1];
            b_top  = b_i[HW-1];
            s_top  = half_d[HW-1];
        end else begin
            sum_o  = full_d[W-1:0];
            cout_o = full_d[W];
            a_top  = a_i[W-1];
            b_top  = b_i[W-1];
            s_top  = full_d[W-1];
        end
        ovf_o = (a_top == b_top) && (s_top != a_top);
    end

endmodule

// File: rtl/alu16_bcd.sv
module alu16_bcd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int ND = W / 4;
    localparam int HW = W / 2;

    logic [W-1:0] dig_d;
    logic [4:0]   part_d;
    logic         chain_d;
    logic         mid_d;

    always_comb begin
        chain_d = cin_i;
        mid_d   = 1'b0;
        dig_d   = '0;
        part_d  = '0;
        for (int g = 0; g < ND; g++) begin
            part_d = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, chain_d};
            if (part_d >= 5'd10) begin
                dig_d[4*g +: 4] = part_d[3:0] + 4'd6;
                chain_d         = 1'b1;
            end else begin
                dig_d[4*g +: 4] = part_d[3:0];
                chain_d         = 1'b0;
            end
            if (g == ND/2 - 1) mid_d = chain_d;
        end
        sum_o  = byte_i ? {{(W-HW){1'b0}}, dig_d[HW-1:0]} : dig_d;
        cout_o = byte_i ? mid_d : chain_d;
    end

endmodule

// File: rtl/alu16_unary.sv
module alu16_unary import alu16_pkg::*; #(
    parameter int W = 16
) (
    input  logic [W-1:0] opnd_i,
    input  logic         cin_i,
    input  unary_e       sel_i,
    input  logic         byte_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int HW = W / 2;

    always_comb begin
        cout_o = opnd_i[0];
        case (sel_i)
            UN_RRC: res_o = byte_i ? {{(W-HW){1'b0}}, cin_i, opnd_i[HW-1:1]}
                                   : {cin_i, opnd_i[W-1:1]};
            UN_RRA: res_o = byte_i ? {{(W-HW){1'b0}}, opnd_i[HW-1], opnd_i[HW-1:1]}
                                   : {opnd_i[W-1], opnd_i[W-1:1]};
            UN_SWPB: res_o = {opnd_i[HW-1:0], opnd_i[W-1:HW]};
            default: res_o = {{(W-HW){opnd_i[HW-1]}}, opnd_i[HW-1:0]};
        endcase
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core import alu16_pkg::*; (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic              carry_i,
    input  logic [3:0]        op_i,
    input  logic              byte_i,
    input  logic              unary_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic              flag_en_o,
    output logic              n_o,
    output logic              z_o,
    output logic              c_o,
    output logic              v_o
);
    localparam int HW = DATA_W / 2;

    two_op_e           opc;
    unary_e            usel;
    logic              full_width;
    logic              narrow;
    logic              sub_mode;
    logic              add_cin;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout, add_ovf;
    logic [DATA_W-1:0] bcd_sum;
    logic              bcd_cout;
    logic [DATA_W-1:0] un_res;
    logic              un_cout;
    flag_cls_e         cls_d;
    logic [DATA_W-1:0] raw_d;
    logic              msb_d, zero_d;
    alu_out_t          out_d;

    assign opc        = two_op_e'(op_i);
    assign usel       = unary_e'(op_i[1:0]);
    assign full_width = unary_i && (usel == UN_SWPB || usel == UN_SXT);
    assign narrow     = byte_i && !full_width;
    assign sub_mode   = (opc == OP_SUBC) || (opc == OP_SUB) || (opc == OP_CMP);
    assign add_b      = sub_mode ? ~src_i : src_i;

    always_comb begin
        case (opc)
            OP_ADDC, OP_SUBC: add_cin = carry_i;
            OP_SUB,  OP_CMP:  add_cin = 1'b1;
            default:          add_cin = 1'b0;
        endcase
    end

    alu16_adder #(.W(DATA_W)) u_adder (
        .a_i    (dst_i),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .byte_i (narrow),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    alu16_bcd #(.W(DATA_W)) u_bcd (
        .a_i    (dst_i),
        .b_i    (src_i),
        .cin_i  (carry_i),
        .byte_i (narrow),
        .sum_o  (bcd_sum),
        .cout_o (bcd_cout)
    );

    alu16_unary #(.W(DATA_W)) u_unary (
        .opnd_i (src_i),
        .cin_i  (carry_i),
        .sel_i  (usel),
        .byte_i (narrow),
        .res_o  (un_res),
        .cout_o (un_cout)
    );

    always_comb begin
        out_d = '0;
        cls_d = FC_NONE;
        raw_d = '0;
        if (unary_i) begin
            raw_d    = un_res;
            out_d.wr = 1'b1;
            case (usel)
                UN_SWPB: cls_d = FC_NONE;
                UN_SXT:  cls_d = FC_LOGIC;
                default: cls_d = FC_SHIFT;
            endcase
        end else begin
            case (opc)
                OP_MOV: begin raw_d = src_i;           out_d.wr = 1'b1; end
                OP_BIC: begin raw_d = dst_i & ~src_i;  out_d.wr = 1'b1; end
                OP_BIS: begin raw_d = dst_i | src_i;   out_d.wr = 1'b1; end
                OP_ADD, OP_ADDC, OP_SUBC, OP_SUB: begin
                    raw_d = add_sum; out_d.wr = 1'b1; cls_d = FC_ARITH;
                end
                OP_CMP:  begin raw_d = add_sum; cls_d = FC_ARITH; end
                OP_DADD: begin raw_d = bcd_sum; out_d.wr = 1'b1; cls_d = FC_BCD; end
                OP_BIT:  begin raw_d = dst_i & src_i; cls_d = FC_LOGIC; end
                OP_XOR:  begin raw_d = dst_i ^ src_i; out_d.wr = 1'b1; cls_d = FC_LOGIC; end
                OP_AND:  begin raw_d = dst_i & src_i; out_d.wr = 1'b1; cls_d = FC_LOGIC; end
                default: raw_d = '0;
            endcase
        end
        if (narrow) raw_d[DATA_W-1:HW] = '0;
        msb_d     = narrow ? raw_d[HW-1] : raw_d[DATA_W-1];
        zero_d    = (raw_d == '0);
        out_d.res = raw_d;
        out_d.fe  = (cls_d != FC_NONE);
        if (cls_d != FC_NONE) begin
            out_d.n = msb_d;
            out_d.z = zero_d;
        end
        case (cls_d)
            FC_ARITH: begin out_d.c = add_cout; out_d.v = add_ovf; end
            FC_LOGIC: out_d.c = !zero_d;
            FC_BCD:   out_d.c = bcd_cout;
            FC_SHIFT: out_d.c = un_cout;
            default:  out_d.c = 1'b0;
        endcase
    end

    assign res_o     = out_d.res;
    assign wr_en_o   = out_d.wr;
    assign flag_en_o = out_d.fe;
    assign n_o       = out_d.n;
    assign z_o       = out_d.z;
    assign c_o       = out_d.c;
    assign v_o       = out_d.v;

    always_comb begin
        if (!unary_i && opc == OP_ADD && src_i == '0 && !byte_i)
            assert_add_identity_R1: assert (res_o == dst_i && !c_o && wr_en_o)
                else $error("add of zero changed operand");
        if (!unary_i && opc == OP_SUB && src_i == '0 && !byte_i)
            assert_sub_no_borrow_R2: assert (c_o && res_o == dst_i)
                else $error("subtract of zero reported borrow");
        if (!unary_i && opc == OP_ADD && !byte_i && !src_i[DATA_W-1]
            && !dst_i[DATA_W-1] && res_o[DATA_W-1])
            assert_add_overflow_R3: assert (v_o)
                else $error("positive overflow not flagged");
        if (flag_en_o && !unary_i && (opc == OP_AND || opc == OP_XOR || opc == OP_BIT))
            assert_logic_carry_R4: assert (c_o == !z_o && !v_o)
                else $error("logical carry rule broken");
        if (!flag_en_o)
            assert_quiet_flags_R5: assert ({n_o, z_o, c_o, v_o} == 4'b0000)
                else $error("flags driven without update");
        if (!unary_i && (opc == OP_CMP || opc == OP_BIT))
            assert_test_no_write_R6: assert (!wr_en_o && flag_en_o)
                else $error("test operation wrote destination");
        if (!unary_i && opc == OP_DADD && byte_i && dst_i[7:4] <= 4'd9 && dst_i[3:0] <= 4'd9
            && src_i[7:4] <= 4'd9 && src_i[3:0] <= 4'd9)
            assert_bcd_digits_R7: assert (res_o[7:4] <= 4'd9 && res_o[3:0] <= 4'd9)
                else $error("decimal digit out of range");
        if (unary_i && usel == UN_SWPB)
            assert_swap_no_flags_R8: assert (wr_en_o && !flag_en_o && res_o == {src_i[HW-1:0], src_i[DATA_W-1:HW]})
                else $error("byte swap misbehaved");
        if (narrow)
            assert_byte_upper_R9: assert (res_o[DATA_W-1:HW] == '0)
                else $error("upper byte not cleared");
        if (!unary_i && op_i < 4'd4)
            assert_unused_code_R10: assert (!wr_en_o && !flag_en_o && res_o == '0)
                else $error("unused code had effect");
        if (flag_en_o && res_o == '0)
            assert_zero_flag_R11: assert (z_o)
                else $error("zero result without zero flag");
    end

endmodule

// File: tb/alu16_core_bench.sv
`timescale 1ns/1ps
module alu16_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src, dst;
    logic        cin, bm, un;
    logic [3:0]  op;
    logic [15:0] res;
    logic        wr, fe, fn, fz, fc, fv;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_core u_alu16_core (
        .src_i(src), .dst_i(dst), .carry_i(cin), .op_i(op), .byte_i(bm), .unary_i(un),
        .res_o(res), .wr_en_o(wr), .flag_en_o(fe),
        .n_o(fn), .z_o(fz), .c_o(fc), .v_o(fv)
    );

    function automatic logic [15:0] pat(input int k);
        case (k)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h7FFF;  3: return 16'h8000;
            4: return 16'h8001;  5: return 16'hFFFF;  6: return 16'h00FF;  7: return 16'h0100;
            8: return 16'hFF00;  9: return 16'h0080;  10: return 16'h007F; 11: return 16'h5555;
            12: return 16'hAAAA; 13: return 16'h1234; 14: return 16'hFEDC; 15: return 16'h0F0F;
            default: return 16'(k * 32'h1357) ^ 16'(k << 11);
        endcase
    endfunction

    // {res[15:0], wr, fe, n, z, c, v}
    function automatic logic [21:0] model(input logic [15:0] s, input logic [15:0] d,
                                          input logic ci, input logic [3:0] o,
                                          input logic b8, input logic u1);
        int wid, mask, sgn, a, b, si, bb, cc, t, sa, sb, st, r, x, cls;
        logic w, f, en, ez, ec, ev;
        r = 0; w = 0; cls = 0; ec = 0; ev = 0;
        si = int'({16'b0, s});
        wid = (u1 && o[0]) ? 16 : (b8 ? 8 : 16);
        mask = (1 << wid) - 1;
        sgn  = 1 << (wid - 1);
        a = int'({16'b0, d}) & mask;
        b = si & mask;
        if (u1) begin
            w = 1;
            case (o[1:0])
                2'd0: begin r = (ci ? sgn : 0) | (b >> 1); ec = (b & 1) != 0; cls = 4; end
                2'd1: r = ((si & 255) << 8) | ((si >> 8) & 255);
                2'd2: begin r = (b & sgn) | (b >> 1); ec = (b & 1) != 0; cls = 4; end
                default: begin r = ((si & 128) != 0) ? ((si & 255) | 65280) : (si & 255); cls = 2; end
            endcase
        end else begin
            case (o)
                4'd4: begin r = b; w = 1; end
                4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
                    bb = (o >= 4'd7) ? ((~b) & mask) : b;
                    cc = (o == 4'd5) ? 0 : ((o == 4'd6 || o == 4'd7) ? int'(ci) : 1);
                    t  = a + bb + cc;
                    r  = t & mask;
                    ec = ((t >> wid) & 1) != 0;
                    sa = (a  >= sgn) ? a  - 2*sgn : a;
                    sb = (bb >= sgn) ? bb - 2*sgn : bb;
                    st = sa + sb + cc;
                    ev = (st >= sgn) || (st < -sgn);
                    w  = (o != 4'd9);
                    cls = 1;
                end
                4'd10: begin
                    cc = int'(ci);
                    for (int k = 0; k < wid/4; k++) begin
                        x = ((a >> (4*k)) & 15) + ((b >> (4*k)) & 15) + cc;
                        if (x >= 10) begin x = (x + 6) & 15; cc = 1; end
                        else cc = 0;
                        r = r | (x << (4*k));
                    end
                    ec = (cc != 0); w = 1; cls = 3;
                end
                4'd11: begin r = a & b; cls = 2; end
                4'd12: begin r = a & ~b & mask; w = 1; end
                4'd13: begin r = a | b; w = 1; end
                4'd14: begin r = a ^ b; w = 1; cls = 2; end
                4'd15: begin r = a & b; w = 1; cls = 2; end
                default: r = 0;
            endcase
        end
        f = (cls != 0);
        if (f) begin
            en = ((r >> (wid - 1)) & 1) != 0;
            ez = (r == 0);
            if (cls == 2) ec = !ez;
        end else begin
            en = 0; ez = 0; ec = 0; ev = 0;
        end
        return {r[15:0], w, f, en, ez, ec, ev};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (op=%0d un=%0b byte=%0b c=%0b src=%h dst=%h)",
                     tag, what, act, exp, op, un, bm, cin, src, dst);
        end
    endtask

    function automatic string res_tag(input logic [3:0] o, input logic b8, input logic u1);
        if (u1) return "R8";
        if (o < 4'd4) return "R10";
        if (b8) return "R9";
        case (o)
            4'd9: return "R6";
            4'd10: return "R7";
            4'd11, 4'd14, 4'd15: return "R4";
            4'd4, 4'd12, 4'd13: return "R5";
            default: return "R1";
        endcase
    endfunction

    function automatic string en_tag(input logic [3:0] o, input logic u1);
        if (u1) return "R8";
        if (o < 4'd4) return "R10";
        case (o)
            4'd9, 4'd11: return "R6";
            4'd4, 4'd12, 4'd13: return "R5";
            default: return "R1";
        endcase
    endfunction

    function automatic string cv_tag(input logic [3:0] o, input logic u1);
        if (u1) return "R8";
        case (o)
            4'd7, 4'd8, 4'd9: return "R2";
            4'd5, 4'd6: return "R3";
            4'd10: return "R7";
            4'd11, 4'd14, 4'd15: return "R4";
            4'd4, 4'd12, 4'd13: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic run_vec(input logic [15:0] s, input logic [15:0] d, input logic ci,
                           input logic [3:0] o, input logic b8, input logic u1);
        logic [21:0] e;
        src = s; dst = d; cin = ci; op = o; bm = b8; un = u1;
        #1;
        e = model(s, d, ci, o, b8, u1);
        check(res_tag(o, b8, u1), "result", {16'b0, res}, {16'b0, e[21:6]});
        check(en_tag(o, u1), "write/flag enables", {30'b0, wr, fe}, {30'b0, e[5:4]});
        check("R11", "N/Z", {30'b0, fn, fz}, {30'b0, e[3:2]});
        check(cv_tag(o, u1), "C/V", {30'b0, fc, fv}, {30'b0, e[1:0]});
        #1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        src = '0; dst = '0; cin = 0; op = '0; bm = 0; un = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // idle inputs: unused code 0 gives quiet outputs (R10)
        check("R10", "idle outputs", {9'b0, res, wr, fe, fn, fz, fc, fv}, 32'h0);

        // two-operand codes, both widths, both carries, operand grid
        for (int o = 0; o < 16; o++)
            for (int b8 = 0; b8 < 2; b8++)
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < 32; i++)
                        for (int j = 0; j < 32; j++)
                            run_vec(pat(i), pat(j), 1'(c), 4'(o), 1'(b8), 1'b0);

        // single-operand group; upper code bits varied to show they are ignored (R8)
        for (int o = 0; o < 4; o++)
            for (int b8 = 0; b8 < 2; b8++)
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < 32; i++)
                        for (int j = 0; j < 32; j++)
                            run_vec(pat(i), pat(j), 1'(c), 4'((o + 4 * (j % 4)) % 16), 1'(b8), 1'b1);

        // every pair of two-digit decimal values in byte mode, checked decimally (R7)
        for (int i = 0; i < 100; i++)
            for (int j = 0; j < 100; j++)
                for (int c = 0; c < 2; c++) begin
                    int tot;
                    logic [7:0] expd;
                    tot  = i + j + c;
                    expd = {4'((tot % 100) / 10), 4'(tot % 10)};
                    src = {8'hA5, 4'(i / 10), 4'(i % 10)};
                    dst = {8'h3C, 4'(j / 10), 4'(j % 10)};
                    cin = 1'(c); op = 4'd10; bm = 1'b1; un = 1'b0;
                    #1;
                    check("R7", "decimal byte sum", {15'b0, fc, res}, {15'b0, 1'(tot >= 100), 8'h00, expd});
                    #1;
                end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule